// File: doc/BRIEF.md
# Accumulator Shift-Add Unit with Condition Flags

This unit keeps two 56-bit signed accumulators, A and B. Each is viewed as an 8-bit extension on top of two 24-bit halves. An execute strobe picks one accumulator as the source and the other as the destination. The destination is doubled by an arithmetic left shift that brings a zero into bit 0. The source is then added, and the sum overwrites the destination. The source is left as it was.

The same writeback updates seven condition flags:

- limit (sticky)
- extension-in-use
- unnormalized
- negative
- zero
- overflow
- carry

Overflow covers two cases: the shift changing the destination's sign bit, and signed overflow of the addition. A surrounding datapath loads the accumulators through two load ports, then issues execute strobes. The result is written two clock edges after the strobe is taken, with a one-cycle done pulse.

Top module: `acc_shadd_unit`

## Requirements
- R1: A synchronous active-high `rst` clears both accumulators, all seven flags and `done`.
- R2: While the unit is idle, `ld_a_en` / `ld_b_en` write `ld_a_val` / `ld_b_val` into A / B on the next clock edge, and loads leave every flag unchanged.
- R3: `dir_sel` = 0 makes B the source and A the destination. `dir_sel` = 1 makes A the source and B the destination. The source accumulator keeps its value.
- R4: The destination becomes (S + 2*D) mod 2^56, where D is shifted left one place with a zero in bit 0. For example, A = 0x00_000000_000123 and B = 0x00_005000_000000 with `dir_sel` = 1 give B = 0x00_00A000_000123.
- R5: `flag_ovf` is set when D bit 55 differs from D bit 54 (the shift alters the sign bit), or when the signed sum does not fit in 56 bits. `flag_cry` is the carry out of bit 55 of the unsigned addition.
- R6: `flag_neg` equals result bit 55. `flag_zero` is 1 exactly when all 56 result bits are 0.
- R7: `flag_ext` is 1 when result bits 55 down to 47 are not all equal. `flag_unn` is 1 when result bits 47 and 46 are equal.
- R8: `flag_lim` is set by any operation that sets `flag_ovf`, and stays set through later operations until reset.
- R9: A strobe taken at clock edge k puts the result, the flags and `done` = 1 on the outputs after edge k+1. `done` is high for exactly one cycle.
- R10: A `start` seen at edge k+1 of an operation in progress is ignored. Load strobes at edges k and k+1 are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_a_en | input | 1 | Load strobe for accumulator A |
| ld_a_val | input | 56 | Value loaded into A |
| ld_b_en | input | 1 | Load strobe for accumulator B |
| ld_b_val | input | 56 | Value loaded into B |
| dir_sel | input | 1 | 0: A += 2A-style with source B; 1: destination B, source A |
| start | input | 1 | Execute strobe |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| flag_lim | output | 1 | Sticky limit flag |
| flag_ext | output | 1 | Extension holds significant bits |
| flag_unn | output | 1 | Result unnormalized |
| flag_neg | output | 1 | Result negative |
| flag_zero | output | 1 | Result zero |
| flag_ovf | output | 1 | Shift or add overflow |
| flag_cry | output | 1 | Carry out of bit 55 |
| done | output | 1 | One-cycle pulse when the result is written |

## Verification
The accumulators, the flags and `done` change together, one edge after the edge that registers the operands, so two edges after the strobe is taken. The bench raises `start` at a falling edge. It checks `done` low at the next falling edge, and checks the result, the flags and `done` high at the falling edge after that. `done` is checked low again one cycle later. Loads and stray strobes are placed on known edges inside the busy window, and the accumulators are read back after it.

// File: rtl/acc_shadd_pkg.sv
package acc_shadd_pkg;

   typedef struct packed {
      logic lim;
      logic ext;
      logic unn;
      logic neg;
      logic zero;
      logic ovf;
      logic cry;
   } ccr_t;

   localparam int CCR_W = $bits(ccr_t);

endpackage

// File: rtl/acc_shadd_opsel.sv
// Operand stage: takes the strobe, steers the accumulators into source and
// destination registers and holds a busy bit for one cycle.
module acc_shadd_opsel #(
   parameter int W = 56
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         dir,
   input  logic [W-1:0] acc_a,
   input  logic [W-1:0] acc_b,
   output logic         accept,
   output logic         vld_q,
   output logic         dir_q,
   output logic [W-1:0] src_q,
   output logic [W-1:0] dst_q
);

   assign accept = start && !vld_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         dir_q <= 1'b0;
         src_q <= '0;
         dst_q <= '0;
      end else begin
         vld_q <= accept;
         if (accept) begin
            dir_q <= dir;
            src_q <= dir ? acc_a : acc_b;
            dst_q <= dir ? acc_b : acc_a;
         end
      end
   end

   // R10: a cycle with an operation in flight never takes a second one
   p_one_in_flight_r10: assert property (@(posedge clk) disable iff (rst)
      vld_q |=> !vld_q);

endmodule

// File: rtl/acc_shadd_core.sv
// Doubling adder: result = src + (dst << 1), with carry and the two
// overflow sources kept apart. SPLIT_ADD picks a chunked ripple form.
module acc_shadd_core #(
   parameter int W         = 56,
   parameter int CHUNK_W   = 8,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic [W-1:0] src,
   input  logic [W-1:0] dst,
   output logic [W-1:0] res,
   output logic         carry,
   output logic         ovf_shift,
   output logic         ovf_add
);

   localparam int NCHUNK = W / CHUNK_W;

   logic [W-1:0] dbl;
   assign dbl = {dst[W-2:0], 1'b0};

   generate
      if (SPLIT_ADD) begin : g_split
         logic [NCHUNK:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
            assign {cy[i+1], res[i*CHUNK_W +: CHUNK_W]} =
               {1'b0, src[i*CHUNK_W +: CHUNK_W]} +
               {1'b0, dbl[i*CHUNK_W +: CHUNK_W]} +
               {{CHUNK_W{1'b0}}, cy[i]};
         end
         assign carry = cy[NCHUNK];
      end else begin : g_flat
         assign {carry, res} = {1'b0, src} + {1'b0, dbl};
      end
   endgenerate

   assign ovf_shift = dst[W-1] ^ dst[W-2];
   assign ovf_add   = (src[W-1] == dbl[W-1]) && (res[W-1] != src[W-1]);

endmodule

// File: rtl/acc_shadd_flags.sv
// Condition-flag generator for the no-scaling view of the accumulator.
module acc_shadd_flags
   import acc_shadd_pkg::*;
#(
   parameter int W     = 56,
   parameter int EXT_W = 8
) (
   input  logic [W-1:0] res,
   input  logic         carry,
   input  logic         ovf_shift,
   input  logic         ovf_add,
   input  logic         lim_prev,
   output ccr_t         ccr
);

   localparam int HEAD_W = EXT_W + 1;
   localparam int TOP    = W - EXT_W - 1;

   logic [HEAD_W-1:0] head;
   logic              ovf;

   assign head = res[W-1 -: HEAD_W];
   assign ovf  = ovf_shift | ovf_add;

   always_comb begin
      ccr.lim  = lim_prev | ovf;
      ccr.ext  = !((&head) || (~|head));
      ccr.unn  = res[TOP] ~^ res[TOP-1];
      ccr.neg  = res[W-1];
      ccr.zero = ~|res;
      ccr.ovf  = ovf;
      ccr.cry  = carry;
   end

endmodule

// File: rtl/acc_shadd_unit.sv
module acc_shadd_unit
   import acc_shadd_pkg::*;
#(
   parameter int ACC_W     = 56,
   parameter int EXT_W     = 8,
   parameter int PART_W    = 24,
   parameter int CHUNK_W   = 8,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_a_en,
   input  logic [ACC_W-1:0] ld_a_val,
   input  logic             ld_b_en,
   input  logic [ACC_W-1:0] ld_b_val,
   input  logic             dir_sel,
   input  logic             start,
   output logic [ACC_W-1:0] acc_a,
   output logic [ACC_W-1:0] acc_b,
   output logic             flag_lim,
   output logic             flag_ext,
   output logic             flag_unn,
   output logic             flag_neg,
   output logic             flag_zero,
   output logic             flag_ovf,
   output logic             flag_cry,
   output logic             done
);

   initial begin
      if (ACC_W != EXT_W + 2 * PART_W)
         $fatal(1, "accumulator width must equal extension plus two halves");
      if (SPLIT_ADD && (ACC_W % CHUNK_W != 0))
         $fatal(1, "chunk width must divide accumulator width");
      if (EXT_W + 2 > ACC_W)
         $fatal(1, "extension too wide for flag window");
   end

   logic [ACC_W-1:0] a_q, b_q;
   ccr_t             ccr_q, ccr_d;
   logic             done_q;

   logic             accept, busy, dir_q;
   logic [ACC_W-1:0] src_q, dst_q, sum;
   logic             carry, ovf_shift, ovf_add;

   acc_shadd_opsel #(.W(ACC_W)) u_opsel (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .dir    (dir_sel),
      .acc_a  (a_q),
      .acc_b  (b_q),
      .accept (accept),
      .vld_q  (busy),
      .dir_q  (dir_q),
      .src_q  (src_q),
      .dst_q  (dst_q)
   );

   acc_shadd_core #(
      .W         (ACC_W),
      .CHUNK_W   (CHUNK_W),
      .SPLIT_ADD (SPLIT_ADD)
   ) u_core (
      .src       (src_q),
      .dst       (dst_q),
      .res       (sum),
      .carry     (carry),
      .ovf_shift (ovf_shift),
      .ovf_add   (ovf_add)
   );

   acc_shadd_flags #(.W(ACC_W), .EXT_W(EXT_W)) u_flags (
      .res       (sum),
      .carry     (carry),
      .ovf_shift (ovf_shift),
      .ovf_add   (ovf_add),
      .lim_prev  (ccr_q.lim),
      .ccr       (ccr_d)
   );

   logic ld_ok;
   assign ld_ok = !busy && !accept;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q    <= '0;
         b_q    <= '0;
         ccr_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= busy;
         if (busy) begin
            ccr_q <= ccr_d;
            if (dir_q) b_q <= sum;
            else       a_q <= sum;
         end else if (ld_ok) begin
            if (ld_a_en) a_q <= ld_a_val;
            if (ld_b_en) b_q <= ld_b_val;
         end
      end
   end

   assign acc_a     = a_q;
   assign acc_b     = b_q;
   assign flag_lim  = ccr_q.lim;
   assign flag_ext  = ccr_q.ext;
   assign flag_unn  = ccr_q.unn;
   assign flag_neg  = ccr_q.neg;
   assign flag_zero = ccr_q.zero;
   assign flag_ovf  = ccr_q.ovf;
   assign flag_cry  = ccr_q.cry;
   assign done      = done_q;

   logic [ACC_W-1:0] dest_now;
   assign dest_now = dir_q ? b_q : a_q;

   // R9: an accepted strobe is followed by busy, then by done
   p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);
   p_busy_done_r9: assert property (@(posedge clk) disable iff (rst)
      busy |=> done);
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R8: limit is sticky and follows overflow
   p_lim_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      flag_lim |=> flag_lim);
   p_ovf_sets_lim_r8: assert property (@(posedge clk) disable iff (rst)
      flag_ovf |-> flag_lim);
   // R6: sign and zero flags agree with the written destination
   p_neg_dest_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> (flag_neg == dest_now[ACC_W-1]));
   p_zero_dest_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> (flag_zero == (dest_now == '0)));
   // R3: the source accumulator is not touched by the writeback
   p_src_hold_r3: assert property (@(posedge clk) disable iff (rst)
      busy |=> (dir_q ? $stable(acc_a) : $stable(acc_b)));

endmodule

// File: tb/acc_shadd_unit_tb_top.sv
`timescale 1ns/1ps
module acc_shadd_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        ld_a_en, ld_b_en, dir_sel, start;
   logic [55:0] ld_a_val, ld_b_val;
   logic [55:0] acc_a, acc_b;
   logic        flag_lim, flag_ext, flag_unn, flag_neg, flag_zero, flag_ovf, flag_cry;
   logic        done;

   always #2.5 clk = ~clk;

   acc_shadd_unit dut_i (
      .clk(clk), .rst(rst),
      .ld_a_en(ld_a_en), .ld_a_val(ld_a_val),
      .ld_b_en(ld_b_en), .ld_b_val(ld_b_val),
      .dir_sel(dir_sel), .start(start),
      .acc_a(acc_a), .acc_b(acc_b),
      .flag_lim(flag_lim), .flag_ext(flag_ext), .flag_unn(flag_unn),
      .flag_neg(flag_neg), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
      .flag_cry(flag_cry), .done(done)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   logic lim_m = 1'b0;

   // vector = {dir_sel, A, B}
   localparam int NV = 7;
   localparam logic [112:0] VEC [NV] = '{
      {1'b1, 56'h00_000000_000123, 56'h00_005000_000000},
      {1'b0, 56'h00_000000_000000, 56'h00_000000_000000},
      {1'b0, 56'h40_000000_000000, 56'h00_000000_000000},
      {1'b0, 56'hFF_FFFFFF_FFFFFF, 56'h00_000000_000002},
      {1'b1, 56'h00_000000_000002, 56'h3F_FFFFFF_FFFFFF},
      {1'b1, 56'hFF_F00000_000001, 56'hFF_C00000_000000},
      {1'b0, 56'h12_345678_9ABCDE, 56'h87_654321_0FEDCB}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] flags_now();
      return {flag_lim, flag_ext, flag_unn, flag_neg, flag_zero, flag_ovf, flag_cry};
   endfunction

   // Returns {result, l,e,u,n,z,v,c} from the stated rules
   function automatic logic [62:0] model(input logic [55:0] s, input logic [55:0] d,
                                         input logic lim_in);
      logic [55:0]        twice;
      logic signed [57:0] tot;
      logic [56:0]        uns;
      logic [55:0]        r;
      logic v, e, u;
      twice = d << 1;
      tot   = $signed({{2{s[55]}}, s}) + $signed({{2{twice[55]}}, twice});
      uns   = {1'b0, s} + {1'b0, twice};
      r     = tot[55:0];
      v     = (d[55] != d[54]) || !(tot[57:55] == 3'b000 || tot[57:55] == 3'b111);
      e     = !(r[55:47] == 9'h000 || r[55:47] == 9'h1FF);
      u     = (r[47] == r[46]);
      return {r, lim_in | v, e, u, r[55], (r == 56'd0), v, uns[56]};
   endfunction

   task automatic load(input logic [55:0] a, input logic [55:0] b);
      @(negedge clk);
      ld_a_en = 1'b1; ld_a_val = a;
      ld_b_en = 1'b1; ld_b_val = b;
      @(negedge clk);
      ld_a_en = 1'b0; ld_b_en = 1'b0;
   endtask

   task automatic run_vec(input logic [112:0] v);
      logic [62:0] m;
      logic [55:0] a0, b0;
      logic        sel;
      logic [6:0]  fl_before;
      sel = v[112]; a0 = v[111:56]; b0 = v[55:0];
      fl_before = flags_now();
      load(a0, b0);
      chk("R2 load A", acc_a, a0);
      chk("R2 load B", acc_b, b0);
      chk("R2 flags kept on load", flags_now(), fl_before);
      m = sel ? model(a0, b0, lim_m) : model(b0, a0, lim_m);
      lim_m = m[6];
      dir_sel = sel; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 no done after first edge", done, 1'b0);
      @(negedge clk);
      chk("R9 done after second edge", done, 1'b1);
      if (sel) begin
         chk("R4 dest B", acc_b, m[62:7]);
         chk("R3 source A kept", acc_a, a0);
      end else begin
         chk("R4 dest A", acc_a, m[62:7]);
         chk("R3 source B kept", acc_b, b0);
      end
      chk("R5 R6 R7 R8 flags", flags_now(), m[6:0]);
      @(negedge clk);
      chk("R9 done one cycle", done, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; start = 1'b0; dir_sel = 1'b0;
      ld_a_en = 1'b0; ld_b_en = 1'b0; ld_a_val = '0; ld_b_val = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 A cleared", acc_a, 56'd0);
      chk("R1 B cleared", acc_b, 56'd0);
      chk("R1 flags cleared", flags_now(), 7'd0);
      chk("R1 done cleared", done, 1'b0);

      for (int i = 0; i < NV; i++) begin
         run_vec(VEC[i]);
         if (i == 0) chk("R4 worked example", acc_b, 56'h00_00A000_000123);
         if (i == 2) chk("R5 shift overflow", flag_ovf, 1'b1);
         if (i == 3) begin
            chk("R5 carry out", flag_cry, 1'b1);
            chk("R8 limit stays set", flag_lim, 1'b1);
         end
      end

      // R10: start held over two edges runs once
      load(56'h00_000000_000010, 56'h00_000000_000001);
      dir_sel = 1'b0; start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R10 single op result", acc_a, 56'h00_000000_000021);
      @(negedge clk);
      chk("R10 second strobe ignored, no done", done, 1'b0);
      @(negedge clk);
      chk("R10 second strobe ignored, A kept", acc_a, 56'h00_000000_000021);

      // R10: load during busy ignored
      load(56'h00_000000_000003, 56'h00_000000_000004);
      dir_sel = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ld_a_en = 1'b1; ld_a_val = 56'h55_555555_555555;
      @(negedge clk);
      ld_a_en = 1'b0;
      chk("R10 load while busy ignored", acc_a, 56'h00_000000_000003);
      chk("R3 R4 dest B", acc_b, 56'h00_000000_00000B);

      // R1 R8: reset clears sticky limit
      chk("R8 limit still set", flag_lim, 1'b1);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 R8 reset clears limit", flag_lim, 1'b0);
      chk("R1 reset clears B", acc_b, 56'd0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule